// File: doc/BRIEF.md
# Oversampling Manchester Frame Receiver

This block takes a single-ended, already-sliced Manchester line running at one eighth of its sample clock (10 Mb/s against 80 MHz) and turns it into a stream of bytes. Because the transmitter runs from its own crystal, the block does not trust its local count alone. Every mid-cell transition re-centres a bit-phase counter, and transitions that fall near a cell boundary are ignored for timing. The first transition after a quiet line is taken as a mid-cell edge, which locks the receiver onto the preamble.

The decoded bits feed a small state machine with three states. `ST_IDLE` means the line is quiet. The first decoded bit moves it to `ST_HUNT`, where it searches the bit history for the start-of-frame pattern. A match moves it to `ST_DATA`, where bits are gathered least significant first into bytes. Each byte is presented as a one-cycle `byte_valid` pulse, and the first byte of a frame also carries `sof`. When the line makes no transition for two bit times, the machine returns to `ST_IDLE`. If it was in `ST_DATA`, it pulses `eof`, and it raises `align_err` with `eof` when a partial byte was left over. The same loss of transitions in `ST_HUNT` drops back to `ST_IDLE` without any output.

Top module: `manch_rx`

## Requirements
- R1: While reset is asserted, `byte_valid`, `sof`, `eof` and `align_err` are all low.
- R2: A bit is decoded from the level after its mid-cell transition: a low-to-high mid transition is 1 and a high-to-low one is 0.
- R3: A transition within two samples of the expected mid-cell point re-centres the bit phase. A transition near the cell boundary is ignored for timing, so half cells of 3 to 5 samples still decode correctly.
- R4: Nothing appears on `byte_valid` or `eof` before the start-of-frame pattern is found. The pattern is the bits 1,0,1,0,1,1 in line order, which is the preamble tail followed by the two closing ones.
- R5: Bits after the pattern are packed least significant bit first. Every 8th bit produces a one-cycle `byte_valid` pulse with the byte on `byte_data`.
- R6: `sof` is high together with `byte_valid` for the first byte of a frame only.
- R7: In `ST_DATA`, 16 consecutive samples without a transition give a one-cycle `eof` that never coincides with `byte_valid`, and the receiver returns to `ST_IDLE`.
- R8: If the frame ends with 1 to 7 bits of an unfinished byte, those bits are not output and `align_err` is high in the same cycle as `eof`. Otherwise `align_err` stays low.
- R9: A preamble that ends without the start-of-frame pattern returns the block to `ST_IDLE` with no `byte_valid` and no `eof`.
- R10: After a quiet line, with the line idling low, the next frame locks again from its first transition and decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 8 samples per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Sliced Manchester line, idles low |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte, valid with `byte_valid` |
| sof | output | 1 | First byte of the frame, valid with `byte_valid` |
| eof | output | 1 | One-cycle pulse at the end of the frame |
| align_err | output | 1 | Frame ended with a partial byte, valid with `eof` |

## Verification
Some rules are checked by the assertions on every cycle:
- bytes appear only out of `ST_DATA`;
- `sof` appears only with a byte, and `align_err` only with `eof`;
- `eof` never coincides with a byte and always leaves the machine in `ST_IDLE`;
- a decoded bit always follows a line transition;
- a boundary transition on a locked receiver never yields a bit.

Other behaviour only the bench scenarios can show:
- byte values and bit order;
- tolerance of slow and fast half cells;
- silent rejection of a preamble without the start-of-frame pattern;
- discarding of a partial byte;
- relocking on the next frame.

The bench shows these by comparing every output event against a queue built from the transmitted frame.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DATA
    } rx_state_e;
endpackage

// File: rtl/manch_edge.sv
module manch_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic edge_det
);
    logic [SYNC_STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[SYNC_STAGES-1:0], line_in};
    end

    assign level    = pipe[SYNC_STAGES-1];
    assign edge_det = pipe[SYNC_STAGES] ^ pipe[SYNC_STAGES-1];
endmodule

// File: rtl/manch_phase.sv
module manch_phase #(
    parameter int SPB   = 8,
    parameter int QUIET = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic edge_det,
    output logic bit_stb,
    output logic bit_val,
    output logic quiet
);
    localparam int PH_W = $clog2(SPB);
    localparam int HALF = SPB / 2;
    localparam int TOL  = SPB / 4;
    localparam int Q_W  = $clog2(QUIET + 1);
    localparam logic [PH_W-1:0] MID_LO   = PH_W'(HALF - TOL);
    localparam logic [PH_W-1:0] MID_HI   = PH_W'(HALF + TOL);
    localparam logic [PH_W-1:0] MID_NEXT = PH_W'((HALF + 1) % SPB);
    localparam logic [PH_W-1:0] PH_MAX   = PH_W'(SPB - 1);
    localparam logic [Q_W-1:0]  Q_LAST   = Q_W'(QUIET - 1);
    localparam logic [Q_W-1:0]  Q_SAT    = Q_W'(QUIET);

    logic [PH_W-1:0] ph;
    logic [Q_W-1:0]  gap;
    logic            locked;
    logic            mid_win;
    logic            take_edge;

    assign mid_win   = (ph >= MID_LO) && (ph <= MID_HI);
    assign take_edge = edge_det && (!locked || mid_win);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= '0;
            gap     <= '0;
            locked  <= 1'b0;
            bit_stb <= 1'b0;
            bit_val <= 1'b0;
            quiet   <= 1'b0;
        end else begin
            bit_stb <= take_edge;
            bit_val <= level;
            quiet   <= 1'b0;
            if (edge_det)          gap <= '0;
            else if (gap != Q_SAT) gap <= gap + 1'b1;
            if (!edge_det && gap == Q_LAST) begin
                quiet  <= 1'b1;
                locked <= 1'b0;
            end
            if (take_edge) begin
                ph     <= MID_NEXT;
                locked <= 1'b1;
            end else begin
                ph <= (ph == PH_MAX) ? '0 : ph + 1'b1;
            end
        end
    end

    // R3: a decoded bit is always caused by a line transition
    p_bit_from_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> $past(edge_det));
    // R3: a boundary transition on a locked receiver yields no bit
    p_boundary_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_det && locked && ph == '0) |=> !bit_stb);
    // R7: the quiet indication never coincides with a bit
    p_quiet_no_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> !bit_stb);
endmodule

// File: rtl/manch_deframe.sv
module manch_deframe
    import manch_rx_pkg::*;
#(
    parameter int              BYTE_W  = 8,
    parameter int              SFD_LEN = 6,
    parameter logic [SFD_LEN-1:0] SFD_PAT = 6'b101011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              quiet,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              sof,
    output logic              eof,
    output logic              align_err
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    rx_state_e          st, nxt;
    logic [SFD_LEN-1:0] hist;
    logic [SFD_LEN-1:0] hist_next;
    logic [BYTE_W-1:0]  sh;
    logic [CNT_W-1:0]   cnt;
    logic               first;
    logic               sfd_hit;

    assign hist_next = {hist[SFD_LEN-2:0], bit_val};
    assign sfd_hit   = bit_stb && (hist_next == SFD_PAT);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (bit_stb) nxt = ST_HUNT;
            ST_HUNT: begin
                if (quiet)        nxt = ST_IDLE;
                else if (sfd_hit) nxt = ST_DATA;
            end
            ST_DATA: if (quiet) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist       <= '0;
            sh         <= '0;
            cnt        <= '0;
            first      <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            sof        <= 1'b0;
            eof        <= 1'b0;
            align_err  <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            sof        <= 1'b0;
            eof        <= 1'b0;
            align_err  <= 1'b0;
            if (quiet)        hist <= '0;
            else if (bit_stb) hist <= hist_next;
            if (st == ST_HUNT && sfd_hit && !quiet) begin
                cnt   <= '0;
                first <= 1'b1;
            end
            if (st == ST_DATA) begin
                if (bit_stb) begin
                    sh <= {bit_val, sh[BYTE_W-1:1]};
                    if (cnt == CNT_LAST) begin
                        byte_valid <= 1'b1;
                        byte_data  <= {bit_val, sh[BYTE_W-1:1]};
                        sof        <= first;
                        first      <= 1'b0;
                        cnt        <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (quiet) begin
                    eof       <= 1'b1;
                    align_err <= (cnt != '0);
                end
            end
        end
    end

    // R4: bytes only come out of the data state
    p_byte_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> ($past(st) == ST_DATA));
    // R6: start marker only with a byte
    p_sof_with_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> byte_valid);
    // R7: end marker leaves the machine idle and never coincides with a byte
    p_eof_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> (st == ST_IDLE && !byte_valid));
    // R8: alignment error only with the end marker
    p_err_with_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> eof);
endmodule

// File: rtl/manch_rx.sv
module manch_rx #(
    parameter int SPB         = 8,
    parameter int QUIET       = 16,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              sof,
    output logic              eof,
    output logic              align_err
);
    logic level, edge_det, bit_stb, bit_val, quiet;

    manch_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .level(level), .edge_det(edge_det)
    );

    manch_phase #(.SPB(SPB), .QUIET(QUIET)) u_phase (
        .clk(clk), .rst_n(rst_n), .level(level), .edge_det(edge_det),
        .bit_stb(bit_stb), .bit_val(bit_val), .quiet(quiet)
    );

    manch_deframe #(.BYTE_W(BYTE_W)) u_deframe (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .quiet(quiet), .byte_valid(byte_valid), .byte_data(byte_data),
        .sof(sof), .eof(eof), .align_err(align_err)
    );
endmodule

// File: tb/sim_manch_rx.sv
module sim_manch_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic       byte_valid, sof, eof, align_err;
    logic [7:0] byte_data;

    manch_rx u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .sof(sof), .eof(eof), .align_err(align_err)
    );

    always #4 clk = ~clk;

    // expected event: {is_eof, flag (sof or align_err), data}
    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] pay[$];
    int checks = 0, fails = 0, stray = 0, drift = 0, bitno = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (byte_valid || eof) begin
                logic [9:0] act;
                act = eof ? {1'b1, align_err, 8'h00} : {1'b0, sof, byte_data};
                if (byte_valid && eof) act = 10'h3ff;
                if (exp_q.size() == 0) begin
                    stray++;
                    check(1'b0, "R4/R9", "output with none expected", act, 0);
                end else begin
                    logic [9:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(act == e, t, "event", act, e);
                end
            end else if (sof || align_err) begin
                check(1'b0, "R6/R8", "flag without event", {sof, align_err}, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic half(input logic lv, input int n);
        repeat (n) begin
            @(negedge clk);
            line_in = lv;
        end
    endtask

    task automatic send_bit(input logic b);
        int h1;
        h1 = 4;
        if (bitno % 5 == 0) h1 = 4 + drift;
        bitno++;
        half(~b, h1);
        half(b, 4);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic preamble();
        for (int i = 0; i < 7; i++) send_byte(8'h55);
        send_byte(8'hD5);
    endtask

    task automatic frame(input string tag, input int extra);
        preamble();
        for (int i = 0; i < pay.size(); i++) begin
            exp_q.push_back({1'b0, (i == 0), pay[i]});
            tag_q.push_back({tag, "/R5/R6"});
        end
        exp_q.push_back({1'b1, (extra != 0), 8'h00});
        tag_q.push_back(extra != 0 ? "R8" : "R7");
        for (int i = 0; i < pay.size(); i++) send_byte(pay[i]);
        for (int i = 0; i < extra; i++) send_bit(i[0]);
        half(1'b0, 40);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(!byte_valid && !sof && !eof && !align_err, "R1", "outputs in reset",
              {byte_valid, sof, eof, align_err}, 0);
        rst_n = 1'b1;
        half(1'b0, 30);
        check(!byte_valid && !sof && !eof && !align_err, "R1", "outputs after reset",
              {byte_valid, sof, eof, align_err}, 0);

        // R2: byte values with all-one and all-zero bits
        pay = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
        frame("R2", 0);

        // R8: partial byte at the end
        pay = '{8'h12, 8'h81, 8'h7E};
        frame("R8", 3);

        // R3: slow transmitter
        drift = 1;
        pay = '{8'h01, 8'h80, 8'hC3, 8'h55, 8'hAA, 8'h96};
        frame("R3", 0);

        // R3: fast transmitter
        drift = -1;
        pay = '{8'hF0, 8'h0F, 8'h99, 8'h66, 8'hE7};
        frame("R3", 5);
        drift = 0;

        // R4, R9: preamble without start pattern gives nothing
        stray = 0;
        for (int i = 0; i < 8; i++) send_byte(8'h55);
        half(1'b0, 40);
        check(stray == 0, "R4/R9", "outputs for preamble only", stray, 0);

        // R7: start pattern then immediate silence
        pay.delete();
        frame("R7", 0);

        // R10: relock on a fresh frame
        pay = '{8'h5A, 8'hC0, 8'hDE};
        frame("R10", 0);

        half(1'b0, 20);
        check(exp_q.size() == 0, "R7", "events outstanding", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule